// File: doc/BRIEF.md
# Vector Memory Address Unit and Line Crossbar

This block sits between the lanes of a vector pipeline and a shared data cache whose port is one line wide. It takes one vector load or store command and breaks it into per-element cache accesses. It supports three addressing modes: unit-stride, constant stride and per-element index. It also handles three element sizes: byte, halfword and word.

A window of memory-lane slots is filled from the address generator. Each slot holds one element's byte address and, for stores, its write data. These filled slots form the request queue. On each cycle the block issues a single line access. That access serves every waiting slot whose address lies in the same line as the oldest waiting slot. Slots in other lines wait for a later cycle.

A read crossbar carries words from the returned line to the read-data lanes, with sign or zero extension. A write crossbar places the store bytes of the served slots into their line positions and raises the matching byte enables. While the cache reports a miss, the block holds the access unchanged and retries it.

Top module: `vec_mem_unit`

## Requirements
- R1: In unit mode (`cmd_mode`=0), element i is at `cmd_base` + i*(element bytes). In strided mode (`cmd_mode`=1), element i is at `cmd_base` + `cmd_stride`*i, where the stride is counted in bytes.
- R2: In indexed mode (`cmd_mode`=2), element i is at `cmd_base` + index i. Index i is bits [32i+31:32i] of `cmd_index`.
- R3: Elements enter the slot window in groups of MEM_LANES (4), in element order. Each accepted access (`c_req`=1, `c_miss`=0) serves every unserved slot in the window whose line matches the oldest unserved slot's line. A 16-word unit-stride access starting on a 64-byte line boundary therefore takes 4 accesses.
- R4: On a load, element i reads its bytes from the returned line at its byte offset within the line, stored little-endian. The result appears on bits [32i+31:32i] of `rd_data`.
- R5: On a store, each served element writes only its own bytes. `c_wdata` carries the bytes and `c_be` bit k enables byte k of the line. When two elements of one access hit the same byte, the higher element number wins. A load drives `c_be` to all zeros.
- R6: While `c_miss` is 1, the access is not taken. `c_req` and `c_addr` hold in the next cycle, and no element is lost or repeated.
- R7: Elements numbered `cmd_vlen` and above (vlen 0..16) cause no access, and their `rd_data` lanes read zero after the command. A vlen of 0 completes with no access at all.
- R8: The size field `cmd_size` selects the element width: 0 is a byte, 1 a halfword, 2 a word. Byte and halfword loads are sign-extended when `cmd_signed` is 1 and zero-extended otherwise. Elements are aligned to their size.
- R9: A command is taken when `cmd_valid` is 1 and `busy` is 0. `busy` then stays 1 until `done` pulses high for exactly one cycle, at which point `busy` returns to 0.
- R10: After a synchronous reset, `busy`, `done` and `c_req` are 0 and `rd_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_mode | input | 2 | 0 unit, 1 strided, 2 indexed |
| cmd_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cmd_signed | input | 1 | Sign-extend narrow loads |
| cmd_base | input | 32 | Base byte address |
| cmd_stride | input | 32 | Stride in bytes |
| cmd_vlen | input | 5 | Number of active elements |
| cmd_index | input | 512 | Per-element byte offsets |
| cmd_wdata | input | 512 | Per-element store data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 512 | Per-element load results |
| c_req | output | 1 | Cache access request |
| c_we | output | 1 | Access is a write |
| c_addr | output | 32 | Line-aligned byte address |
| c_wdata | output | 512 | Line write data |
| c_be | output | 64 | Line byte enables |
| c_rdata | input | 512 | Line read data, same cycle |
| c_miss | input | 1 | Access not taken, retry |

## Verification
The bench sweeps the stride from 0 to 68 bytes and compares the access count against a count of line groups per window worked out in the bench. A design that grouped too little would issue extra accesses. One that grouped across the oldest line would serve elements out of order.

Vector lengths from 0 to 16 expose lanes past the length that wrongly issue accesses or keep stale data. Narrow stores with odd strides catch byte enables that spill onto neighbouring bytes. Duplicate indices catch the wrong element winning a byte. Narrow signed loads catch a dropped sign extension.

Runs with pseudo-random misses repeat the loads and stores. They catch slots that get marked served on a refused access, or whose data is lost or written twice.

// File: rtl/vmu_pkg.sv
package vmu_pkg;

    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        AM_UNIT    = 2'd0,
        AM_STRIDED = 2'd1,
        AM_INDEXED = 2'd2
    } amode_e;

    typedef enum logic [1:0] {
        ES_BYTE = 2'd0,
        ES_HALF = 2'd1,
        ES_WORD = 2'd2
    } esize_e;

    // one memory-lane request slot
    typedef struct packed {
        logic              valid;
        logic              done;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } slot_t;

    function automatic logic [2:0] elem_bytes(esize_e sz);
        case (sz)
            ES_BYTE: return 3'd1;
            ES_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] extend_load(logic [WORD_W-1:0] raw,
                                                      esize_e sz, logic sgn);
        case (sz)
            ES_BYTE: return sgn ? {{(WORD_W-8){raw[7]}}, raw[7:0]}
                                : {{(WORD_W-8){1'b0}}, raw[7:0]};
            ES_HALF: return sgn ? {{(WORD_W-16){raw[15]}}, raw[15:0]}
                                : {{(WORD_W-16){1'b0}}, raw[15:0]};
            default: return raw;
        endcase
    endfunction

endpackage

// File: rtl/vmu_addr_gen.sv
module vmu_addr_gen
    import vmu_pkg::*;
#(
    parameter int NUM_LANES = 16,
    parameter int MEM_LANES = 4,
    parameter int CW        = $clog2(NUM_LANES + 1)
) (
    input  amode_e                             mode,
    input  esize_e                             size,
    input  logic [ADDR_W-1:0]                  base,
    input  logic [ADDR_W-1:0]                  stride,
    input  logic [NUM_LANES*ADDR_W-1:0]        index_flat,
    input  logic [CW:0]                        first_elem,
    output logic [MEM_LANES-1:0][ADDR_W-1:0]   addr
);
    localparam int LW = $clog2(NUM_LANES);

    logic [ADDR_W-1:0] step;
    assign step = (mode == AM_UNIT) ? ADDR_W'(elem_bytes(size)) : stride;

    for (genvar s = 0; s < MEM_LANES; s++) begin : g_lane
        logic [CW:0]       elem;
        logic [LW-1:0]     li;
        logic [ADDR_W-1:0] idx_off;
        logic [ADDR_W-1:0] str_off;
        assign elem    = first_elem + (CW+1)'(s);
        assign li      = elem[LW-1:0];
        assign idx_off = index_flat[li*ADDR_W +: ADDR_W];
        assign str_off = step * ADDR_W'(elem);
        // per-lane choice between stride product and index
        assign addr[s] = base + ((mode == AM_INDEXED) ? idx_off : str_off);
    end

endmodule

// File: rtl/vmu_line_xbar.sv
module vmu_line_xbar
    import vmu_pkg::*;
#(
    parameter int MEM_LANES  = 4,
    parameter int LINE_BYTES = 64,
    parameter int OFFW       = $clog2(LINE_BYTES)
) (
    input  logic [MEM_LANES-1:0]               serve,
    input  logic [MEM_LANES-1:0][OFFW-1:0]     offs,
    input  logic [MEM_LANES-1:0][WORD_W-1:0]   wdata,
    input  esize_e                             size,
    input  logic                               sgn,
    input  logic [LINE_BYTES*8-1:0]            rline,
    output logic [LINE_BYTES*8-1:0]            wline,
    output logic [LINE_BYTES-1:0]              be,
    output logic [MEM_LANES-1:0][WORD_W-1:0]   rd
);
    localparam int WB = WORD_W / 8;

    logic [OFFW-1:0]   pos;
    logic [WORD_W-1:0] raw;
    logic [2:0]        nb;

    assign nb = elem_bytes(size);

    // write crossbar: higher slot overrides lower on overlap
    always_comb begin
        wline = '0;
        be    = '0;
        pos   = '0;
        for (int s = 0; s < MEM_LANES; s++) begin
            for (int b = 0; b < WB; b++) begin
                pos = offs[s] + OFFW'(b);
                if (serve[s] && (3'(b) < nb)) begin
                    wline[pos*8 +: 8] = wdata[s][b*8 +: 8];
                    be[pos]           = 1'b1;
                end
            end
        end
    end

    // read crossbar with extension
    always_comb begin
        rd = '0;
        for (int s = 0; s < MEM_LANES; s++) begin
            raw = '0;
            for (int b = 0; b < WB; b++) begin
                raw[b*8 +: 8] = rline[(offs[s] + OFFW'(b))*8 +: 8];
            end
            rd[s] = extend_load(raw, size, sgn);
        end
    end

endmodule

// File: rtl/vec_mem_unit.sv
module vec_mem_unit
    import vmu_pkg::*;
#(
    parameter int NUM_LANES  = 16,
    parameter int MEM_LANES  = 4,
    parameter int LINE_BYTES = 64,
    parameter int CW         = $clog2(NUM_LANES + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cmd_valid,
    input  logic                          cmd_store,
    input  logic [1:0]                    cmd_mode,
    input  logic [1:0]                    cmd_size,
    input  logic                          cmd_signed,
    input  logic [ADDR_W-1:0]             cmd_base,
    input  logic [ADDR_W-1:0]             cmd_stride,
    input  logic [CW-1:0]                 cmd_vlen,
    input  logic [NUM_LANES*ADDR_W-1:0]   cmd_index,
    input  logic [NUM_LANES*WORD_W-1:0]   cmd_wdata,
    output logic                          busy,
    output logic                          done,
    output logic [NUM_LANES*WORD_W-1:0]   rd_data,
    output logic                          c_req,
    output logic                          c_we,
    output logic [ADDR_W-1:0]             c_addr,
    output logic [LINE_BYTES*8-1:0]       c_wdata,
    output logic [LINE_BYTES-1:0]         c_be,
    input  logic [LINE_BYTES*8-1:0]       c_rdata,
    input  logic                          c_miss
);
    localparam int LW   = $clog2(NUM_LANES);
    localparam int OFFW = $clog2(LINE_BYTES);
    localparam int LNW  = ADDR_W - OFFW;

    logic                        busy_q, done_q, store_q, sgn_q;
    amode_e                      mode_q;
    esize_e                      size_q;
    logic [ADDR_W-1:0]           base_q, stride_q;
    logic [CW-1:0]               vlen_q;
    logic [NUM_LANES*ADDR_W-1:0] index_q;
    logic [WORD_W-1:0]           wdata_q [NUM_LANES];
    logic [WORD_W-1:0]           rd_q    [NUM_LANES];
    logic [CW:0]                 gen_ptr, win_base;
    slot_t                       win     [MEM_LANES];

    logic [MEM_LANES-1:0][ADDR_W-1:0] gen_addr;
    logic [MEM_LANES-1:0][CW:0]       gen_elem, srv_elem;
    logic [MEM_LANES-1:0]             serve;
    logic [MEM_LANES-1:0][OFFW-1:0]   offs;
    logic [MEM_LANES-1:0][WORD_W-1:0] slot_wd, xb_rd;
    logic [LINE_BYTES*8-1:0]          xb_wline;
    logic [LINE_BYTES-1:0]            xb_be;
    logic                             pending;
    logic [LNW-1:0]                   lead_line;
    logic [CW:0]                      vlen_x;

    assign vlen_x = {1'b0, vlen_q};

    vmu_addr_gen #(.NUM_LANES(NUM_LANES), .MEM_LANES(MEM_LANES), .CW(CW)) u_agen (
        .mode(mode_q), .size(size_q), .base(base_q), .stride(stride_q),
        .index_flat(index_q), .first_elem(gen_ptr), .addr(gen_addr)
    );

    for (genvar s = 0; s < MEM_LANES; s++) begin : g_slot
        assign gen_elem[s] = gen_ptr  + (CW+1)'(s);
        assign srv_elem[s] = win_base + (CW+1)'(s);
        assign offs[s]     = win[s].addr[OFFW-1:0];
        assign slot_wd[s]  = win[s].wdata;
        assign serve[s]    = pending && win[s].valid && !win[s].done &&
                             (win[s].addr[ADDR_W-1:OFFW] == lead_line);
    end

    // oldest unserved slot sets the line for this cycle
    always_comb begin
        pending   = 1'b0;
        lead_line = '0;
        for (int s = 0; s < MEM_LANES; s++) begin
            if (!pending && win[s].valid && !win[s].done) begin
                pending   = 1'b1;
                lead_line = win[s].addr[ADDR_W-1:OFFW];
            end
        end
    end

    vmu_line_xbar #(.MEM_LANES(MEM_LANES), .LINE_BYTES(LINE_BYTES)) u_xbar (
        .serve(serve), .offs(offs), .wdata(slot_wd), .size(size_q), .sgn(sgn_q),
        .rline(c_rdata), .wline(xb_wline), .be(xb_be), .rd(xb_rd)
    );

    assign busy    = busy_q;
    assign done    = done_q;
    assign c_req   = busy_q && pending;
    assign c_we    = c_req && store_q;
    assign c_addr  = {lead_line, {OFFW{1'b0}}};
    assign c_wdata = store_q ? xb_wline : '0;
    assign c_be    = (c_req && store_q) ? xb_be : '0;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_rd
        assign rd_data[l*WORD_W +: WORD_W] = rd_q[l];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            store_q  <= 1'b0;
            sgn_q    <= 1'b0;
            mode_q   <= AM_UNIT;
            size_q   <= ES_WORD;
            vlen_q   <= '0;
            gen_ptr  <= '0;
            win_base <= '0;
            for (int s = 0; s < MEM_LANES; s++) win[s] <= '0;
            for (int l = 0; l < NUM_LANES; l++) rd_q[l] <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (cmd_valid) begin
                    busy_q   <= 1'b1;
                    store_q  <= cmd_store;
                    mode_q   <= amode_e'(cmd_mode);
                    size_q   <= esize_e'(cmd_size);
                    sgn_q    <= cmd_signed;
                    base_q   <= cmd_base;
                    stride_q <= cmd_stride;
                    vlen_q   <= cmd_vlen;
                    index_q  <= cmd_index;
                    gen_ptr  <= '0;
                    win_base <= '0;
                    for (int s = 0; s < MEM_LANES; s++) win[s] <= '0;
                    for (int l = 0; l < NUM_LANES; l++) begin
                        rd_q[l]    <= '0;
                        wdata_q[l] <= cmd_wdata[l*WORD_W +: WORD_W];
                    end
                end
            end else if (pending) begin
                if (!c_miss) begin
                    for (int s = 0; s < MEM_LANES; s++) begin
                        if (serve[s]) begin
                            win[s].done <= 1'b1;
                            if (!store_q) rd_q[srv_elem[s][LW-1:0]] <= xb_rd[s];
                        end
                    end
                end
            end else if (gen_ptr < vlen_x) begin
                for (int s = 0; s < MEM_LANES; s++) begin
                    win[s].valid <= gen_elem[s] < vlen_x;
                    win[s].done  <= 1'b0;
                    win[s].addr  <= gen_addr[s];
                    win[s].wdata <= wdata_q[gen_elem[s][LW-1:0]];
                end
                win_base <= gen_ptr;
                gen_ptr  <= gen_ptr + (CW+1)'(MEM_LANES);
            end else begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
        end
    end

    AST_HOLD_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        (c_req && c_miss) |=> (c_req && $stable(c_addr))); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !c_req); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy)); // R9
    AST_LOAD_NO_BE: assert property (@(posedge clk) disable iff (rst)
        (c_req && !c_we) |-> (c_be == '0)); // R5
    AST_IN_LENGTH: assert property (@(posedge clk) disable iff (rst)
        c_req |-> (win_base < vlen_x)); // R7
    AST_STORE_HAS_BE: assert property (@(posedge clk) disable iff (rst)
        c_we |-> (c_be != '0)); // R5

endmodule

// File: tb/test_vec_mem_unit.sv
module test_vec_mem_unit;

    logic         clk = 1'b0;
    logic         rst;
    logic         cmd_valid, cmd_store, cmd_signed;
    logic [1:0]   cmd_mode, cmd_size;
    logic [31:0]  cmd_base, cmd_stride;
    logic [4:0]   cmd_vlen;
    logic [511:0] cmd_index, cmd_wdata;
    logic         busy, done;
    logic [511:0] rd_data;
    logic         c_req, c_we;
    logic [31:0]  c_addr;
    logic [511:0] c_wdata, c_rdata;
    logic [63:0]  c_be;
    logic         c_miss;

    always #4 clk = ~clk;

    vec_mem_unit i_vec_mem_unit (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_store(cmd_store),
        .cmd_mode(cmd_mode), .cmd_size(cmd_size), .cmd_signed(cmd_signed),
        .cmd_base(cmd_base), .cmd_stride(cmd_stride), .cmd_vlen(cmd_vlen),
        .cmd_index(cmd_index), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .c_req(c_req), .c_we(c_we), .c_addr(c_addr),
        .c_wdata(c_wdata), .c_be(c_be), .c_rdata(c_rdata), .c_miss(c_miss)
    );

    logic [7:0]  mem     [1024];
    logic [7:0]  exp_mem [1024];
    logic [31:0] idx [16];
    logic [31:0] wd  [16];
    int checks = 0, errors = 0, acc_cnt = 0, cyc = 0;
    logic miss_en = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    // cache model: same-cycle read, write on accepted access
    always_comb begin
        for (int b = 0; b < 64; b++) c_rdata[b*8 +: 8] = mem[{c_addr[9:6], 6'(b)}];
    end
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (c_req && !c_miss) begin
            acc_cnt <= acc_cnt + 1;
            if (c_we)
                for (int b = 0; b < 64; b++)
                    if (c_be[b]) mem[{c_addr[9:6], 6'(b)}] <= c_wdata[b*8 +: 8];
        end
    end
    always @(negedge clk) begin
        lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        c_miss <= miss_en && lfsr[0];
    end

    always @(posedge clk) begin
        if (cyc > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic init_mem();
        for (int i = 0; i < 1024; i++) begin
            mem[i]     = 8'((i * 37 + 11) ^ (i >> 3));
            exp_mem[i] = mem[i];
        end
    endtask

    function automatic logic [31:0] e_addr(input logic [1:0] md, input logic [1:0] sz,
                                           input logic [31:0] b, input logic [31:0] s, input int i);
        if (md == 2) return b + idx[i];
        if (md == 0) return b + 32'(i) * (32'd1 << sz);
        return b + s * 32'(i);
    endfunction

    function automatic logic [31:0] e_load(input logic [1:0] md, input logic [1:0] sz, input logic sg,
                                           input logic [31:0] b, input logic [31:0] s, input int i);
        logic [31:0] a = e_addr(md, sz, b, s, i);
        logic [31:0] r = 0;
        for (int k = 0; k < (1 << sz); k++) r[k*8 +: 8] = exp_mem[(a + 32'(k)) & 32'd1023];
        if (sz == 0) return sg ? {{24{r[7]}}, r[7:0]} : {24'd0, r[7:0]};
        if (sz == 1) return sg ? {{16{r[15]}}, r[15:0]} : {16'd0, r[15:0]};
        return r;
    endfunction

    function automatic int e_acc(input logic [1:0] md, input logic [1:0] sz,
                                 input logic [31:0] b, input logic [31:0] s, input int vl);
        int n = 0;
        for (int w = 0; w < vl; w += 4) begin
            logic [3:0] left = 0;
            for (int j = 0; j < 4; j++) left[j] = (w + j) < vl;
            while (left != 0) begin
                logic [25:0] ln = 0;
                logic got = 0;
                for (int j = 0; j < 4; j++)
                    if (left[j] && !got) begin got = 1; ln = e_addr(md, sz, b, s, w + j) >> 6; end
                for (int j = 0; j < 4; j++)
                    if (left[j] && ((e_addr(md, sz, b, s, w + j) >> 6) == 32'(ln))) left[j] = 0;
                n++;
            end
        end
        return n;
    endfunction

    task automatic run(input logic st, input logic [1:0] md, input logic [1:0] sz, input logic sg,
                       input logic [31:0] b, input logic [31:0] s, input int vl);
        int t = 0;
        @(negedge clk);
        cmd_valid = 1; cmd_store = st; cmd_mode = md; cmd_size = sz; cmd_signed = sg;
        cmd_base = b; cmd_stride = s; cmd_vlen = 5'(vl);
        for (int i = 0; i < 16; i++) begin
            cmd_index[i*32 +: 32] = idx[i];
            cmd_wdata[i*32 +: 32] = wd[i];
        end
        acc_cnt = 0;
        @(negedge clk);
        cmd_valid = 0;
        chk("R9 busy after accept", 32'(busy), 1);
        while (!done && t < 3000) begin @(negedge clk); t++; end
        if (t >= 3000) chk("R9 watchdog", 0, 1);
        @(negedge clk);
        chk("R9 done one cycle, busy low", {30'd0, done, busy}, 0);
        if (st)
            for (int i = 0; i < vl; i++) begin
                logic [31:0] a = e_addr(md, sz, b, s, i);
                for (int k = 0; k < (1 << sz); k++) exp_mem[(a + 32'(k)) & 32'd1023] = wd[i][k*8 +: 8];
            end
    endtask

    task automatic chk_load(input string req, input logic [1:0] md, input logic [1:0] sz, input logic sg,
                            input logic [31:0] b, input logic [31:0] s, input int vl);
        for (int i = 0; i < 16; i++)
            chk(req, rd_data[i*32 +: 32], (i < vl) ? e_load(md, sz, sg, b, s, i) : 32'd0);
        chk("R3 access count", 32'(acc_cnt), 32'(e_acc(md, sz, b, s, vl)));
    endtask

    task automatic chk_mem(input string req);
        int bad = -1;
        for (int i = 0; i < 1024; i++) if (bad < 0 && mem[i] !== exp_mem[i]) bad = i;
        if (bad < 0) chk(req, 0, 0);
        else chk(req, {bad[15:0], 8'd0, mem[bad]}, {bad[15:0], 8'd0, exp_mem[bad]});
    endtask

    initial begin
        rst = 1; cmd_valid = 0; cmd_store = 0; cmd_mode = 0; cmd_size = 2; cmd_signed = 0;
        cmd_base = 0; cmd_stride = 0; cmd_vlen = 0; cmd_index = 0; cmd_wdata = 0;
        for (int i = 0; i < 16; i++) begin
            idx[i] = 32'(i * 52 + (i % 3) * 8);
            wd[i]  = 32'h8000_0000 ^ 32'(i * 32'h0101_0F33 + 7);
        end
        init_mem();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state
        chk("R10 busy", 32'(busy), 0);
        chk("R10 done", 32'(done), 0);
        chk("R10 c_req", 32'(c_req), 0);
        chk("R10 rd_data", 32'(rd_data != 0), 0);

        // R1 R3 R4 unit word load, line aligned: 4 accesses
        run(0, 0, 2, 0, 32'h80, 0, 16);
        chk_load("R4 unit word load", 0, 2, 0, 32'h80, 0, 16);
        chk("R3 aligned unit-stride accesses", 32'(acc_cnt), 4);

        // R1 R3 stride sweep
        for (int k = 0; k <= 17; k++) begin
            run(0, 1, 2, 0, 32'h100, 32'(k * 4), 16);
            chk_load("R1 strided word load", 1, 2, 0, 32'h100, 32'(k * 4), 16);
        end

        // R2 indexed word load
        run(0, 2, 2, 0, 32'h40, 0, 16);
        chk_load("R2 indexed word load", 2, 2, 0, 32'h40, 0, 16);

        // R8 narrow loads, signed and unsigned
        run(0, 0, 0, 1, 32'h13, 0, 16);
        chk_load("R8 signed byte load", 0, 0, 1, 32'h13, 0, 16);
        run(0, 1, 0, 0, 32'h7, 32'd3, 16);
        chk_load("R8 unsigned byte load", 1, 0, 0, 32'h7, 32'd3, 16);
        run(0, 0, 1, 1, 32'h3A, 0, 16);
        chk_load("R8 signed half load", 0, 1, 1, 32'h3A, 0, 16);
        run(0, 2, 1, 0, 32'h20, 0, 16);
        chk_load("R8 unsigned half indexed load", 2, 1, 0, 32'h20, 0, 16);

        // R7 length sweep
        for (int v = 0; v <= 16; v++) begin
            run(0, 0, 2, 0, 32'h1C0, 0, v);
            chk_load("R7 short vector load", 0, 2, 0, 32'h1C0, 0, v);
        end

        // R5 stores
        init_mem();
        run(1, 0, 2, 0, 32'h200, 0, 16);
        chk_mem("R5 unit word store");
        chk("R3 store accesses", 32'(acc_cnt), 4);
        run(1, 1, 0, 0, 32'h301, 32'd5, 16);
        chk_mem("R5 strided byte store, neighbours kept");
        run(1, 2, 1, 0, 32'h10, 0, 11);
        chk_mem("R5 R7 indexed half store, short length");
        for (int i = 0; i < 16; i++) idx[i] = 32'((i / 2) * 4);
        run(1, 2, 2, 0, 32'h380, 0, 8);
        chk_mem("R5 duplicate index, higher element wins");
        chk("R3 duplicate index accesses", 32'(acc_cnt), 2);

        // R6 misses
        for (int i = 0; i < 16; i++) idx[i] = 32'(i * 52 + (i % 3) * 8);
        miss_en = 1;
        run(0, 1, 2, 0, 32'h100, 32'd20, 16);
        chk_load("R6 strided load under misses", 1, 2, 0, 32'h100, 32'd20, 16);
        run(0, 2, 0, 1, 32'h40, 0, 13);
        chk_load("R6 indexed byte load under misses", 2, 0, 1, 32'h40, 0, 13);
        run(1, 1, 1, 0, 32'h220, 32'd6, 16);
        chk_mem("R6 strided store under misses");
        chk("R6 store accesses under misses", 32'(acc_cnt), 32'(e_acc(1, 1, 32'h220, 32'd6, 16)));
        miss_en = 0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule